// File: doc/BRIEF.md
# Self-Clocking Single-Wire Bit Decoder

This block turns a single-wire serial line into a stream of decoded bits and two framing events. Every bit opens with a rising edge on the line. The receiver learns the bit period from the first two rising edges of a frame. A `1` is sent as an extra rising edge early in the bit, and a `0` as the lack of one. The line is oversampled by a fast system clock. The block presents each decoded bit as a one-cycle strobe with its value.

The decoder also watches how long the line has gone without a new leading edge. A medium idle gap produces a one-cycle end-of-sequence pulse, which a downstream shift path uses to close one word. A long idle gap produces a one-cycle latch pulse, which commits the data. The latch pulse also re-arms the period measurement, so the next frame can run at a new rate.

A measured period outside the supported range makes the decoder ignore that frame completely. It stays silent until the line has been idle for eight maximum periods.

Top module: `swd_bit_decoder`

## Requirements
- R1: While reset is asserted, and afterwards until the first rising edge, the outputs `bit_vld_o`, `eos_o` and `lat_o` stay low.
- R2: In the armed state, the distance in system clocks between the first two rising edges becomes the period T. If MIN_PER <= T <= MAX_PER, two `0` bits are strobed on consecutive cycles. The first is strobed 2 cycles after the system clock edge that first samples the second rising edge.
- R3: A rising edge that comes d cycles after a bit's leading edge, with 2·d < T, decodes that bit as `1`. The strobe appears 2 cycles after the edge that first samples the extra rise. The rise does not restart the bit timing.
- R4: A bit with no extra rise decodes as `0`. Its strobe appears ceil(T/2) + 2 cycles after the edge that first samples the bit's leading edge.
- R5: In a measured frame, 32 bits are strobed in line order: the two measurement bits followed by 30 data bits.
- R6: Exactly one end-of-sequence pulse appears per idle gap. It never coincides with a latch pulse.
- R7: The latch pulse appears 8·T + 2 cycles after the sampling edge of the last leading edge. The next frame is then measured afresh and may use a different T.
- R8: A rising edge after an end-of-sequence pulse but before the latch starts a new bit with the stored T. No new measurement is made.
- R9: If the measured T is below MIN_PER, no bit, end-of-sequence or latch output appears until the line has gone 8·MAX_PER cycles without a rising edge. After that, a valid frame decodes normally.
- R10: If no second rising edge arrives within MAX_PER cycles of the first, the frame is handled as in R9.
- R11: The end-of-sequence pulse appears ceil(7·T/2) + 2 cycles after the sampling edge of the last leading edge. This timing holds even when that bit was a `1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the line |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Asynchronous single-wire serial line |
| bit_vld_o | output | 1 | One-cycle strobe for a decoded bit |
| bit_val_o | output | 1 | Value of the decoded bit, valid with the strobe |
| eos_o | output | 1 | One-cycle end-of-sequence pulse |
| lat_o | output | 1 | One-cycle latch pulse; the period measurement re-arms |

## Verification
A line rise needs two synchroniser flops and one output register to reach the outputs. For that reason every result is due a fixed 2 cycles after the clock edge that first samples the edge that causes it:
- a `1` strobe is due 2 cycles after the extra rise is first sampled;
- a `0` strobe, the end-of-sequence pulse and the latch pulse are due ceil(T/2), ceil(7·T/2) and 8·T cycles later still, counted from the leading edge.

The bench drives the line on falling clock edges and records the clock count at which it will first be sampled. A monitor logs, on falling edges, the cycle of every output pulse. Each check compares a logged cycle with the figure computed from T and the recorded edge cycles.

// File: rtl/swd_pkg.sv
package swd_pkg;

  typedef enum logic [2:0] {
    ST_ARM,   // waiting for the first edge of a frame
    ST_MEAS,  // first edge seen, measuring the period
    ST_OPEN,  // leading edge seen, bit value not yet known
    ST_DONE,  // bit decided, waiting for next leading edge or idle events
    ST_HALT   // bad period, waiting for a long idle
  } swd_state_t;

  // d = cycles since the leading edge, p = stored period
  function automatic logic extra_is_one(input int unsigned d, input int unsigned p);
    return (2 * d) < p;
  endfunction

  function automatic logic half_elapsed(input int unsigned d, input int unsigned p);
    return (2 * d) >= p;
  endfunction

  function automatic logic eos_due(input int unsigned d, input int unsigned p);
    return (2 * d) >= (7 * p);
  endfunction

  function automatic logic lat_due(input int unsigned d, input int unsigned p);
    return d >= (8 * p);
  endfunction

endpackage

// File: rtl/swd_edge_sync.sv
module swd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], rx_in};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/swd_gap_timer.sv
module swd_gap_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  output logic [CW-1:0] gap_o
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap_o <= '0;
    else if (restart_i)  gap_o <= '0;
    else if (gap_o != TOP) gap_o <= gap_o + 1'b1;
  end
endmodule

// File: rtl/swd_frame_fsm.sv
module swd_frame_fsm
  import swd_pkg::*;
#(
  parameter int MIN_PER = 100,
  parameter int MAX_PER = 5000,
  parameter int CW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic [CW-1:0] gap_i,
  output logic          restart_o,
  output logic          bit_vld_o,
  output logic          bit_val_o,
  output logic          eos_o,
  output logic          lat_o
);
  localparam int PW = $clog2(MAX_PER + 1);
  localparam int unsigned LO = MIN_PER;
  localparam int unsigned HI = MAX_PER;

  swd_state_t    st_q, st_d;
  logic [PW-1:0] per_q, per_d;
  logic          pend_q, pend_d;
  logic          eos_seen_q, eos_seen_d;
  logic          vld_d, val_d, eos_d, lat_d;
  int unsigned   d, p;

  assign d = 32'(gap_i) + 32'd1;
  assign p = 32'(per_q);

  always_comb begin
    st_d       = st_q;
    per_d      = per_q;
    pend_d     = 1'b0;
    eos_seen_d = eos_seen_q;
    vld_d      = pend_q;
    val_d      = 1'b0;
    eos_d      = 1'b0;
    lat_d      = 1'b0;
    restart_o  = 1'b0;
    case (st_q)
      ST_ARM: if (rise_i) begin
        restart_o = 1'b1;
        st_d      = ST_MEAS;
      end
      ST_MEAS: begin
        if (rise_i) begin
          restart_o = 1'b1;
          if (d >= LO && d <= HI) begin
            per_d      = PW'(d);
            vld_d      = 1'b1;
            pend_d     = 1'b1;
            eos_seen_d = 1'b0;
            st_d       = ST_DONE;
          end else begin
            st_d = ST_HALT;
          end
        end else if (d > HI) begin
          st_d = ST_HALT;
        end
      end
      ST_OPEN: begin
        if (rise_i && extra_is_one(d, p)) begin
          vld_d = 1'b1;
          val_d = 1'b1;
          st_d  = ST_DONE;
        end else if (rise_i) begin
          vld_d     = 1'b1;
          restart_o = 1'b1;
        end else if (half_elapsed(d, p)) begin
          vld_d = 1'b1;
          st_d  = ST_DONE;
        end
      end
      ST_DONE: begin
        if (rise_i) begin
          restart_o  = 1'b1;
          eos_seen_d = 1'b0;
          st_d       = ST_OPEN;
        end else if (lat_due(d, p)) begin
          lat_d = 1'b1;
          st_d  = ST_ARM;
        end else if (eos_due(d, p) && !eos_seen_q) begin
          eos_d      = 1'b1;
          eos_seen_d = 1'b1;
        end
      end
      ST_HALT: begin
        if (rise_i)              restart_o = 1'b1;
        else if (lat_due(d, HI)) st_d      = ST_ARM;
      end
      default: st_d = ST_ARM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_ARM;
      per_q      <= PW'(MIN_PER);
      pend_q     <= 1'b0;
      eos_seen_q <= 1'b0;
      bit_vld_o  <= 1'b0;
      bit_val_o  <= 1'b0;
      eos_o      <= 1'b0;
      lat_o      <= 1'b0;
    end else begin
      st_q       <= st_d;
      per_q      <= per_d;
      pend_q     <= pend_d;
      eos_seen_q <= eos_seen_d;
      bit_vld_o  <= vld_d;
      bit_val_o  <= val_d;
      eos_o      <= eos_d;
      lat_o      <= lat_d;
    end
  end

  // R9
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_o |-> (32'(per_q) >= LO && 32'(per_q) <= HI));

  // R3
  one_from_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld_o && bit_val_o) |-> $past(st_q) == ST_OPEN);

  // R6
  eos_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eos_o |-> !$past(eos_seen_q));

  // R6
  eos_lat_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(eos_o && lat_o));

  // R7
  lat_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_o |-> st_q == ST_ARM);

  // R10
  halt_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st_q) == ST_HALT |-> !(bit_vld_o || eos_o || lat_o));
endmodule

// File: rtl/swd_bit_decoder.sv
module swd_bit_decoder #(
  parameter int MIN_PER = 100,
  parameter int MAX_PER = 5000,
  parameter int SYNC    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic bit_vld_o,
  output logic bit_val_o,
  output logic eos_o,
  output logic lat_o
);
  localparam int CW = $clog2(8 * MAX_PER + 2);

  logic          rise;
  logic          restart;
  logic [CW-1:0] gap;

  swd_edge_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rise_o(rise)
  );

  swd_gap_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .gap_o(gap)
  );

  swd_frame_fsm #(.MIN_PER(MIN_PER), .MAX_PER(MAX_PER), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .gap_i(gap),
    .restart_o(restart), .bit_vld_o(bit_vld_o), .bit_val_o(bit_val_o),
    .eos_o(eos_o), .lat_o(lat_o)
  );
endmodule

// File: tb/swd_bit_decoder_tb.sv
module swd_bit_decoder_tb;
  localparam int MAXP = 5000;
  localparam int W    = 10;

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b0;
  logic bit_vld, bit_val, eos, lat;
  int   cyc = 0, total = 0, bad = 0;

  logic bits [64];
  int   bcyc [64];
  int   nb, neos, nlat, eos_cyc, lat_cyc;
  int   lead [32];
  int   midc [32];
  int   nl;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  swd_bit_decoder #(.MIN_PER(100), .MAX_PER(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx),
    .bit_vld_o(bit_vld), .bit_val_o(bit_val), .eos_o(eos), .lat_o(lat)
  );

  always @(negedge clk) begin
    if (bit_vld && nb < 64) begin bits[nb] = bit_val; bcyc[nb] = cyc; nb = nb + 1; end
    if (eos) begin neos = neos + 1; eos_cyc = cyc; end
    if (lat) begin nlat = nlat + 1; lat_cyc = cyc; end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    nb = 0; neos = 0; nlat = 0; nl = 0; eos_cyc = 0; lat_cyc = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input int p, input logic v, input int mid);
    lead[nl] = cyc + 1;
    rx = 1'b1; idle(W); rx = 1'b0;
    if (v) begin
      idle(mid - W);
      midc[nl] = cyc + 1;
      rx = 1'b1; idle(W); rx = 1'b0;
      idle(p - mid - W);
    end else begin
      idle(p - W);
    end
    nl = nl + 1;
  endtask

  task automatic send_word(input int p, input logic [31:0] w, input int mid);
    for (int i = 31; i >= 0; i--) send_bit(p, w[i], mid);
  endtask

  task automatic chk_word(input logic [31:0] w, input string req);
    int errs = 0;
    chk(nb == 32, req, nb, 32);
    for (int i = 0; i < 32; i++) if (bits[i] !== w[31-i]) errs++;
    chk(errs == 0, req, errs, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rx = 1'b0; clr();
    idle(5);
    chk(!bit_vld && !eos && !lat, "R1 in reset", {bit_vld, eos, lat}, 0);
    rst_n = 1'b1;
    idle(20);
    chk(nb == 0 && neos == 0 && nlat == 0, "R1 after reset", nb + neos + nlat, 0);
  endtask

  task automatic t_frame_a();
    clr();
    send_word(200, 32'h3A12C57F, 50);
    chk_word(32'h3A12C57F, "R5 frame T=200");
    chk(bcyc[0] == lead[1] + 2, "R2 first zero", bcyc[0], lead[1] + 2);
    chk(bcyc[1] == lead[1] + 3, "R2 second zero", bcyc[1], lead[1] + 3);
    chk(bcyc[2] == midc[2] + 2, "R3 one strobe", bcyc[2], midc[2] + 2);
    chk(bcyc[5] == lead[5] + 102, "R4 zero strobe", bcyc[5], lead[5] + 102);
    idle(700);
    chk(neos == 1, "R6 eos count", neos, 1);
    chk(eos_cyc == lead[31] + 702, "R11 eos timing after one", eos_cyc, lead[31] + 702);
    chk(nlat == 0, "R6 no latch yet", nlat, 0);
  endtask

  task automatic t_continue();
    clr();
    send_word(200, 32'hA5F00F5A, 50);
    chk_word(32'hA5F00F5A, "R8 continuation");
    idle(1420);
    chk(neos == 1, "R6 eos once", neos, 1);
    chk(nlat == 1, "R7 latch count", nlat, 1);
    chk(lat_cyc == lead[31] + 1602, "R7 latch timing", lat_cyc, lead[31] + 1602);
    chk(eos_cyc == lead[31] + 702, "R11 eos timing", eos_cyc, lead[31] + 702);
  endtask

  task automatic t_rearm();
    clr();
    send_word(120, 32'h3A55AA01, 59);
    chk_word(32'h3A55AA01, "R7 new period R3 edge 2d=T-2");
    idle(860);
    chk(nlat == 1 && lat_cyc == lead[31] + 962, "R7 latch T=120", lat_cyc, lead[31] + 962);
  endtask

  task automatic t_bad_short();
    clr();
    send_word(50, 32'h3AFFFFFF, 12);
    idle(500);
    chk(nb == 0 && neos == 0 && nlat == 0, "R9 short ignored", nb + neos + nlat, 0);
    idle(8 * MAXP);
    clr();
    send_word(150, 32'h2C0FF0E1, 37);
    chk_word(32'h2C0FF0E1, "R9 recovery");
    idle(1100);
    chk(nlat == 1, "R9 latch after recovery", nlat, 1);
  endtask

  task automatic t_bad_long();
    clr();
    rx = 1'b1; idle(W); rx = 1'b0;
    idle(6000);
    for (int i = 0; i < 4; i++) send_bit(200, 1'b1, 50);
    idle(8 * MAXP + 10);
    chk(nb == 0 && neos == 0 && nlat == 0, "R10 long ignored", nb + neos + nlat, 0);
    clr();
    send_word(100, 32'h3A000001, 25);
    chk_word(32'h3A000001, "R10 recovery at min period R2");
    idle(720);
    chk(nlat == 1 && lat_cyc == lead[31] + 802, "R7 latch T=100", lat_cyc, lead[31] + 802);
  endtask

  initial begin
    t_reset();
    t_frame_a();
    t_continue();
    t_rearm();
    t_bad_short();
    t_bad_long();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    total = total + 1; bad = bad + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule